// File: doc/BRIEF.md
# Chain-Compatible Serial Slave with Frame-Length Check

This block is a serial slave that shares a daisy chain with byte-oriented devices. It has an active-low select, a serial clock, a serial data input and a serial data output. All of these are brought into the system clock domain and their edges are found there. While the select is low, each falling edge of the serial clock shifts one input bit into a 16-bit register, MSB first. Each rising edge drives the register's top bit onto the serial output, so bits travel on to the next device in the chain.

A chain that contains 8-bit devices has no single frame length. So when the select rises, the block accepts any frame of 16 bits plus a whole number of 8-bit bytes. For an accepted frame, the last 16 bits received go to a parallel output and a one-cycle strobe is raised. Any other length discards the data and raises a one-cycle error flag instead. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_chain_slave`

## Requirements
- R1: Input bits are taken on falling serial-clock edges while selected, MSB first. On an accepted frame `rx_data` holds the last 16 bits received: the earliest of them in bit 15, the latest in bit 0.
- R2: A frame of N clock pulses is accepted on the select rising edge exactly when N >= 16 and (N - 16) is a multiple of 8. The acceptance is marked by a one-cycle `rx_valid` pulse.
- R3: Any other length gives a one-cycle `frame_err` pulse with no `rx_valid`, and `rx_data` keeps its previous value.
- R4: On each rising serial-clock edge while selected, `sdo` takes the register MSB. The register is cleared when the select falls, so for output bit i (counted from 0) `sdo` is 0 when i < 16 and equals input bit i-16 otherwise.
- R5: `sdo` is 0 whenever the synchronized select is high.
- R6: Serial clock and data activity with the select high has no effect: no pulse on `rx_valid` or `frame_err`, and `sdo` stays 0.
- R7: Frame length is checked correctly for frames of any length. The count saturates at 16 and then tracks the position within a byte, so a 336-bit frame is accepted and a 330-bit frame is rejected.
- R8: The count clears on every select falling edge, so a rejected 8-bit frame followed by a 16-bit frame gives an accepted frame.
- R9: `rx_valid` and `frame_err` are never high together, and `rx_data` changes only in a cycle in which `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Active-low device select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next device |
| rx_data | output | 16 | Last accepted 16-bit word |
| rx_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_err | output | 1 | One-cycle flag for a rejected frame length |

## Verification
On every cycle, the assertions check that the output is zero while the select is high and that both pulses last one cycle. They also check that the accept and reject outcomes never occur together and that the parallel word changes only with the strobe. The bench scenarios are needed to show the length rule itself, for short, long and mid-byte frames. They also show the bit order of the captured word, the pass-through delay of 16 bits, and that the count restarts after a rejected frame.

// File: rtl/spi_chain_slave.sv
`timescale 1ns/1ps
module spi_chain_slave #(
  parameter int WORD_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PH_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [SYNC_STAGES:0]   cs_pipe, sclk_pipe;
  logic [SYNC_STAGES-1:0] sdi_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      sdi_pipe  <= '0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_STAGES-1:0], cs_n};
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-1:0], sclk};
      sdi_pipe  <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
    end
  end

  logic cs_s, cs_d, sclk_s, sclk_d, sdi_s;
  assign cs_s   = cs_pipe[SYNC_STAGES-1];
  assign cs_d   = cs_pipe[SYNC_STAGES];
  assign sclk_s = sclk_pipe[SYNC_STAGES-1];
  assign sclk_d = sclk_pipe[SYNC_STAGES];
  assign sdi_s  = sdi_pipe[SYNC_STAGES-1];

  logic sel, cs_fall, cs_rise, clk_fall, clk_rise;
  assign sel      = ~cs_s;
  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign clk_fall = sel & sclk_d & ~sclk_s;
  assign clk_rise = sel & ~sclk_d & sclk_s;

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  word_cnt;
  logic [PH_W-1:0]   phase;
  logic              word_full, frame_ok;

  assign word_full = (word_cnt == FULL);
  assign frame_ok  = word_full && (phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      word_cnt <= '0;
      phase    <= '0;
    end else if (cs_fall) begin
      shreg    <= '0;
      word_cnt <= '0;
      phase    <= '0;
    end else if (clk_fall) begin
      shreg <= {shreg[WORD_W-2:0], sdi_s};
      if (!word_full) word_cnt <= word_cnt + 1'b1;
      else            phase    <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sdo <= 1'b0;
    else if (cs_s)     sdo <= 1'b0;
    else if (clk_rise) sdo <= shreg[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= cs_rise & frame_ok;
      frame_err <= cs_rise & ~frame_ok;
      if (cs_rise && frame_ok) rx_data <= shreg;
    end
  end

endmodule

// File: rtl/spi_chain_slave_chk.sv
`timescale 1ns/1ps
module spi_chain_slave_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_sync,
  input logic              sdo,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              frame_err
);

  // R5
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> !sdo);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && frame_err));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);

endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_s), .sdo(sdo),
  .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
);

// File: tb/tb_spi_chain_slave.sv
`timescale 1ns/1ps
module tb_spi_chain_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, rx_valid, frame_err;
  logic [15:0] rx_data;

  spi_chain_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, n_valid = 0, n_err = 0;
  bit finished = 0;
  logic stream [0:399];
  logic seen   [0:399];

  always @(posedge clk) begin
    if (rx_valid)  n_valid <= n_valid + 1;
    if (frame_err) n_err   <= n_err + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 400; i++) stream[i] = (((i * 7 + seed) * 13) % 5) > 1;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input string req);
    int v0, e0;
    logic [15:0] d0, exp_d;
    bit ok, pass_ok;
    v0 = n_valid; e0 = n_err; d0 = rx_data;
    cs_n = 1'b0; wait_clk(6);
    for (int i = 0; i < n; i++) begin
      sdi = stream[i]; sclk = 1'b1; wait_clk(6);
      seen[i] = sdo; sclk = 1'b0; wait_clk(6);
    end
    cs_n = 1'b1; wait_clk(8);
    ok = (n >= 16) && (((n - 16) % 8) == 0);
    exp_d = d0;
    if (ok) for (int k = 0; k < 16; k++) exp_d[15 - k] = stream[n - 16 + k];
    chk((n_valid - v0) == (ok ? 1 : 0), {req, " R2 strobe count"}, n_valid - v0, ok ? 1 : 0);
    chk((n_err - e0) == (ok ? 0 : 1), {req, " R3 error count"}, n_err - e0, ok ? 0 : 1);
    chk(rx_data == exp_d, {req, ok ? " R1 captured word" : " R3 word held"}, rx_data, exp_d);
    pass_ok = 1;
    for (int i = 0; i < n; i++)
      if (seen[i] !== ((i < 16) ? 1'b0 : stream[i - 16])) pass_ok = 0;
    chk(pass_ok, {req, " R4 pass-through"}, pass_ok, 1);
    chk(sdo == 1'b0, {req, " R5 sdo idle"}, sdo, 0);
  endtask

  task automatic t_reset;
    chk(rx_valid == 0 && frame_err == 0, "R2 reset pulses", {rx_valid, frame_err}, 0);
    chk(rx_data == 16'h0, "R1 reset data", rx_data, 0);
    chk(sdo == 0, "R5 reset sdo", sdo, 0);
  endtask

  task automatic t_deselected;
    int v0, e0;
    bit quiet;
    v0 = n_valid; e0 = n_err; quiet = 1;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0]; sclk = 1'b1; wait_clk(6);
      if (sdo !== 1'b0) quiet = 0;
      sclk = 1'b0; wait_clk(6);
    end
    wait_clk(8);
    chk(n_valid == v0 && n_err == e0, "R6 no pulses when deselected", n_valid - v0 + n_err - e0, 0);
    chk(quiet, "R6 sdo quiet when deselected", quiet, 1);
  endtask

  initial begin
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    t_reset();
    fill(1);  frame(16,  "R1 16-bit");
    fill(2);  frame(24,  "R1 24-bit");
    fill(3);  frame(32,  "R4 32-bit");
    fill(4);  frame(40,  "R2 40-bit");
    fill(5);  frame(8,   "R3 8-bit");
    fill(6);  frame(20,  "R3 20-bit");
    fill(7);  frame(0,   "R3 empty");
    fill(8);  frame(16,  "R8 after reject");
    t_deselected();
    fill(9);  frame(336, "R7 long accept");
    fill(10); frame(330, "R7 long reject");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3ms;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule